// File: doc/BRIEF.md
# Parallel Port Host Register Block

This block is the register set a host processor sees for a PC-style parallel printer port. A small synchronous bus carries a 3-bit offset, a write strobe, a read strobe and 8-bit write data. Three locations are decoded: the data byte at offset 0, the read-only line status at offset 1 and the line control byte at offset 2. The block drives the eight data lines and the three control lines toward the cable. It samples the data lines and five status inputs for host reads. Read data is registered and appears one cycle after the read strobe, together with a valid flag.

A 3-bit mode input selects what a write to offset 0 does. In the two plain data-port modes it loads the output data register. In the extended-capability mode it pushes the byte, marked as an address/run-length byte, into a 16-entry forward queue. A downstream cable engine drains that queue through a pop input, and the entry appears one cycle after the pop. Reverse direction, the other transfer modes, test mode and configuration mode are not handled here.

Top module: `pport_host_regs`

## Requirements
- R1: After a synchronous reset, pd_out is 0x00, strobe_n and autofd_n are 1, init_o is 0, the queue is empty (fifo_empty=1, fifo_full=0) and fifo_ovf is 0.
- R2: In mode 3'b000 or 3'b001, a write to offset 0 makes pd_out equal the written byte, without inversion, from the cycle after the write.
- R3: A read of offset 0 returns the level of pd_in sampled at the read in modes 3'b000 and 3'b001, and returns 0x00 in every other mode. Read data is valid on bus_rdata while rd_valid=1, one cycle after bus_rd.
- R4: A read of offset 1 returns 0 in bits 2..0, fault_n_i in bit 3, select_i in bit 4, perror_i in bit 5, ack_n_i in bit 6 and the inverse of busy_i in bit 7.
- R5: A write to offset 2 stores bits 5..0, and a read of offset 2 returns them with bits 7..6 equal to 0.
- R6: strobe_n is the inverse of control bit 0, autofd_n is the inverse of control bit 1, and init_o equals control bit 2. Each follows a control write from the next cycle.
- R7: In mode 3'b011 with control bit 5 (direction) equal to 0, a write to offset 0 pushes a 9-bit entry {tag=1, byte} into the queue. Tag value 1 marks an address/run-length byte.
- R8: In mode 3'b011 with control bit 5 equal to 1, a write to offset 0 leaves the queue unchanged.
- R9: The queue holds 16 entries and delivers them in push order. fifo_full is 1 exactly when 16 entries are held, and fifo_empty is 1 exactly when none are held.
- R10: A push into a full queue is dropped and sets fifo_ovf, which then stays 1 until reset.
- R11: A write to offset 0 in any mode other than 3'b000 and 3'b001 leaves pd_out unchanged.
- R12: A pop of a non-empty queue sets fifo_rvalid for one cycle with the oldest entry on fifo_tag and fifo_byte. A pop of an empty queue produces no fifo_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 3 | Port operating mode |
| bus_off | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | bus_rdata valid |
| pd_out | output | 8 | Data lines driven to the cable |
| pd_in | input | 8 | Data line levels sampled from the cable |
| strobe_n | output | 1 | Active-low strobe line |
| autofd_n | output | 1 | Active-low auto line-feed line |
| init_o | output | 1 | Initialise line |
| fault_n_i | input | 1 | Active-low fault status |
| select_i | input | 1 | Select status |
| perror_i | input | 1 | Paper error status |
| ack_n_i | input | 1 | Active-low acknowledge status |
| busy_i | input | 1 | Busy status |
| fifo_pop | input | 1 | Pop the oldest queue entry |
| fifo_rvalid | output | 1 | Popped entry valid |
| fifo_tag | output | 1 | Tag of popped entry |
| fifo_byte | output | 8 | Byte of popped entry |
| fifo_empty | output | 1 | Queue holds no entries |
| fifo_full | output | 1 | Queue holds 16 entries |
| fifo_ovf | output | 1 | Sticky drop-on-full flag |

## Verification
On every cycle the assertions check several fixed properties. They check the zero bits and the inverted busy bit of the status byte, and the zero upper bits of a control read. They check the polarity of each control line after a write, and that full and empty are never both set. They check that the overflow flag never clears, that a reverse-direction push leaves the queue level unchanged, and that pd_out holds through writes in non-data modes. Only the bench scenarios can show first-in-first-out ordering, the exact 16-entry capacity, the tag value on popped entries, the pd_in read-back, and that a dropped byte never reappears.

// File: rtl/pport_pkg.sv
package pport_pkg;
  localparam int DW = 8;
  localparam int OFFW = 3;

  localparam logic [2:0] MODE_SPP  = 3'b000;
  localparam logic [2:0] MODE_BIDI = 3'b001;
  localparam logic [2:0] MODE_ECP  = 3'b011;

  localparam logic [2:0] OFF_DATA = 3'd0;
  localparam logic [2:0] OFF_STAT = 3'd1;
  localparam logic [2:0] OFF_CTRL = 3'd2;

  localparam int CTRL_W  = 6;
  localparam int DIR_BIT = 5;

  typedef struct packed {
    logic          tag;
    logic [DW-1:0] dat;
  } q_entry_t;
endpackage

// File: rtl/pport_port_regs.sv
module pport_port_regs
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [OFFW-1:0]   bus_off,
  input  logic              bus_wr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     pd_out,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              strobe_n,
  output logic              autofd_n,
  output logic              init_o,
  output logic              push,
  output q_entry_t          push_data
);
  logic data_mode;
  logic wr_data, wr_ctrl;

  assign data_mode = (mode == MODE_SPP) || (mode == MODE_BIDI);
  assign wr_data   = bus_wr && (bus_off == OFF_DATA);
  assign wr_ctrl   = bus_wr && (bus_off == OFF_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      pd_out <= '0;
    end else if (wr_data && data_mode) begin
      pd_out <= bus_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      strobe_n <= 1'b1;
      autofd_n <= 1'b1;
      init_o   <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q   <= bus_wdata[CTRL_W-1:0];
      strobe_n <= ~bus_wdata[0];
      autofd_n <= ~bus_wdata[1];
      init_o   <= bus_wdata[2];
    end
  end

  assign push          = wr_data && (mode == MODE_ECP) && !ctrl_q[DIR_BIT];
  assign push_data.tag = 1'b1;
  assign push_data.dat = bus_wdata;
endmodule

// File: rtl/pport_tag_fifo.sv
module pport_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic         rvalid,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full,
  output logic         ovf,
  output logic [$clog2(DEPTH):0] level
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wptr, rptr;
  logic         do_push, do_pop;

  assign empty   = (wptr == rptr);
  assign full    = (wptr[AW] != rptr[AW]) && (wptr[AW-1:0] == rptr[AW-1:0]);
  assign level   = wptr - rptr;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (do_pop) rdata <= mem[rptr[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr   <= '0;
      rptr   <= '0;
      rvalid <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      rvalid <= do_pop;
      if (do_push) wptr <= wptr + 1'b1;
      if (do_pop)  rptr <= rptr + 1'b1;
      if (push && full) ovf <= 1'b1;
    end
  end
endmodule

// File: rtl/pport_read_mux.sv
module pport_read_mux
  import pport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  input  logic [OFFW-1:0]   bus_off,
  input  logic              bus_rd,
  input  logic [DW-1:0]     pd_in,
  input  logic [CTRL_W-1:0] ctrl_q,
  input  logic              fault_n_i,
  input  logic              select_i,
  input  logic              perror_i,
  input  logic              ack_n_i,
  input  logic              busy_i,
  output logic [DW-1:0]     bus_rdata,
  output logic              rd_valid
);
  logic [DW-1:0] stat_b, ctrl_b, sel_b;

  assign stat_b = {~busy_i, ack_n_i, perror_i, select_i, fault_n_i, 3'b000};
  assign ctrl_b = {{(DW-CTRL_W){1'b0}}, ctrl_q};

  always_comb begin
    sel_b = '0;
    case (bus_off)
      OFF_DATA: if (mode == MODE_SPP || mode == MODE_BIDI) sel_b = pd_in;
      OFF_STAT: sel_b = stat_b;
      OFF_CTRL: sel_b = ctrl_b;
      default:  sel_b = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_valid  <= 1'b0;
    end else begin
      rd_valid <= bus_rd;
      if (bus_rd) bus_rdata <= sel_b;
    end
  end
endmodule

// File: rtl/pport_host_regs.sv
module pport_host_regs
  import pport_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [2:0]    mode,
  input  logic [2:0]    bus_off,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          rd_valid,
  output logic [7:0]    pd_out,
  input  logic [7:0]    pd_in,
  output logic          strobe_n,
  output logic          autofd_n,
  output logic          init_o,
  input  logic          fault_n_i,
  input  logic          select_i,
  input  logic          perror_i,
  input  logic          ack_n_i,
  input  logic          busy_i,
  input  logic          fifo_pop,
  output logic          fifo_rvalid,
  output logic          fifo_tag,
  output logic [7:0]    fifo_byte,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          fifo_ovf
);
  localparam int EW = $bits(q_entry_t);
  localparam int LW = $clog2(FIFO_DEPTH) + 1;

  logic [CTRL_W-1:0] ctrl_q;
  logic              push;
  q_entry_t          push_data;
  q_entry_t          pop_data;
  logic [LW-1:0]     fifo_level;

  pport_port_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .bus_off   (bus_off),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .pd_out    (pd_out),
    .ctrl_q    (ctrl_q),
    .strobe_n  (strobe_n),
    .autofd_n  (autofd_n),
    .init_o    (init_o),
    .push      (push),
    .push_data (push_data)
  );

  pport_tag_fifo #(.DEPTH(FIFO_DEPTH), .W(EW)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (push),
    .push_data (push_data),
    .pop       (fifo_pop),
    .rvalid    (fifo_rvalid),
    .rdata     (pop_data),
    .empty     (fifo_empty),
    .full      (fifo_full),
    .ovf       (fifo_ovf),
    .level     (fifo_level)
  );

  pport_read_mux u_rmux (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode),
    .bus_off   (bus_off),
    .bus_rd    (bus_rd),
    .pd_in     (pd_in),
    .ctrl_q    (ctrl_q),
    .fault_n_i (fault_n_i),
    .select_i  (select_i),
    .perror_i  (perror_i),
    .ack_n_i   (ack_n_i),
    .busy_i    (busy_i),
    .bus_rdata (bus_rdata),
    .rd_valid  (rd_valid)
  );

  assign fifo_tag  = pop_data.tag;
  assign fifo_byte = pop_data.dat;
endmodule

// File: rtl/pport_host_regs_chk.sv
module pport_host_regs_chk #(
  parameter int LW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic [2:0]    mode,
  input logic [2:0]    bus_off,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [7:0]    bus_wdata,
  input logic [7:0]    bus_rdata,
  input logic [7:0]    pd_out,
  input logic          strobe_n,
  input logic          autofd_n,
  input logic          init_o,
  input logic          busy_i,
  input logic          fifo_pop,
  input logic          fifo_empty,
  input logic          fifo_full,
  input logic          fifo_ovf,
  input logic [5:0]    ctrl_q,
  input logic [LW-1:0] fifo_level
);
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (pd_out == 8'h00 && strobe_n && autofd_n && !init_o && fifo_empty && !fifo_ovf));

  p_status_bits_r4: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_off == 3'd1) |=> (bus_rdata[2:0] == 3'b000 && bus_rdata[7] == ~$past(busy_i)));

  p_ctrl_high_zero_r5: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_off == 3'd2) |=> (bus_rdata[7:6] == 2'b00));

  p_line_polarity_r6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_off == 3'd2) |=>
      (strobe_n == ~$past(bus_wdata[0]) && autofd_n == ~$past(bus_wdata[1]) && init_o == $past(bus_wdata[2])));

  p_reverse_no_push_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_off == 3'd0 && mode == 3'b011 && ctrl_q[5] && !fifo_pop) |=> $stable(fifo_level));

  p_flags_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  p_ovf_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    fifo_ovf |=> fifo_ovf);

  p_pd_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_off == 3'd0 && mode != 3'b000 && mode != 3'b001) |=> $stable(pd_out));
endmodule

bind pport_host_regs pport_host_regs_chk #(.LW(LW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode       (mode),
  .bus_off    (bus_off),
  .bus_wr     (bus_wr),
  .bus_rd     (bus_rd),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pd_out     (pd_out),
  .strobe_n   (strobe_n),
  .autofd_n   (autofd_n),
  .init_o     (init_o),
  .busy_i     (busy_i),
  .fifo_pop   (fifo_pop),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .fifo_ovf   (fifo_ovf),
  .ctrl_q     (ctrl_q),
  .fifo_level (fifo_level)
);

// File: tb/test_pport_host_regs.sv
`timescale 1ns/1ps
module test_pport_host_regs;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode = 3'b000;
  logic [2:0] bus_off = 3'd0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       rd_valid;
  logic [7:0] pd_out;
  logic [7:0] pd_in = 8'h00;
  logic       strobe_n, autofd_n, init_o;
  logic       fault_n_i = 1'b0, select_i = 1'b0, perror_i = 1'b0, ack_n_i = 1'b0, busy_i = 1'b0;
  logic       fifo_pop = 1'b0;
  logic       fifo_rvalid, fifo_tag;
  logic [7:0] fifo_byte;
  logic       fifo_empty, fifo_full, fifo_ovf;

  int n_chk = 0, n_bad = 0;
  logic [7:0] rq[$];
  string      rn[$];
  logic [8:0] fq[$];
  string      fn[$];

  always #10 clk = ~clk;

  pport_host_regs i_pport_host_regs (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] o, input logic [7:0] d);
    @(negedge clk); bus_off = o; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] o, input logic [7:0] exp, input string req);
    @(negedge clk); bus_off = o; bus_rd = 1'b1; rq.push_back(exp); rn.push_back(req);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic pop(input logic [8:0] exp, input string req);
    @(negedge clk); fifo_pop = 1'b1; fq.push_back(exp); fn.push_back(req);
    @(negedge clk); fifo_pop = 1'b0;
  endtask

  // monitor: compares produced results with the scoreboard queues
  always @(negedge clk) begin
    if (rd_valid) begin
      if (rq.size() == 0) chk("R3 unexpected rd_valid", 16'd1, 16'd0);
      else chk(rn.pop_front(), {8'h00, bus_rdata}, {8'h00, rq.pop_front()});
    end
    if (fifo_rvalid) begin
      if (fq.size() == 0) chk("R12 unexpected fifo_rvalid", 16'd1, 16'd0);
      else chk(fn.pop_front(), {7'h00, fifo_tag, fifo_byte}, {7'h00, fq.pop_front()});
    end
  end

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd_out", {8'h0, pd_out}, 16'h0000);
    chk("R1 lines", {13'h0, strobe_n, autofd_n, init_o}, 16'b110);
    chk("R1 fifo flags", {13'h0, fifo_empty, fifo_full, fifo_ovf}, 16'b100);
    rd(3'd2, 8'h00, "R1 ctrl after reset");

    // R2 / R3 data-port modes
    wr(3'd0, 8'hA5);
    chk("R2 pd_out mode000", {8'h0, pd_out}, 16'h00A5);
    pd_in = 8'h3C;
    rd(3'd0, 8'h3C, "R3 pd_in read mode000");
    mode = 3'b001;
    wr(3'd0, 8'h5A);
    chk("R2 pd_out mode001", {8'h0, pd_out}, 16'h005A);
    pd_in = 8'hC3;
    rd(3'd0, 8'hC3, "R3 pd_in read mode001");
    mode = 3'b010;
    wr(3'd0, 8'hFF);
    chk("R11 pd_out hold mode010", {8'h0, pd_out}, 16'h005A);
    rd(3'd0, 8'h00, "R3 read zero mode010");

    // R4 status
    fault_n_i = 1'b1; select_i = 1'b0; perror_i = 1'b1; ack_n_i = 1'b0; busy_i = 1'b1;
    rd(3'd1, 8'h28, "R4 status A");
    fault_n_i = 1'b0; perror_i = 1'b0; busy_i = 1'b0;
    rd(3'd1, 8'h80, "R4 status B");
    select_i = 1'b1; ack_n_i = 1'b1; busy_i = 1'b1;
    rd(3'd1, 8'h50, "R4 status C");

    // R5 / R6 control
    wr(3'd2, 8'hFF);
    rd(3'd2, 8'h3F, "R5 ctrl readback");
    chk("R6 lines all set", {13'h0, strobe_n, autofd_n, init_o}, 16'b001);
    wr(3'd2, 8'h02);
    chk("R6 lines autofd only", {13'h0, strobe_n, autofd_n, init_o}, 16'b100);
    wr(3'd2, 8'h05);
    chk("R6 lines strobe+init", {13'h0, strobe_n, autofd_n, init_o}, 16'b011);

    // R7 / R9 tagged pushes in forward direction
    mode = 3'b011;
    wr(3'd2, 8'h00);
    wr(3'd0, 8'h11);
    chk("R7 not empty after push", {15'h0, fifo_empty}, 16'h0000);
    chk("R11 pd_out hold mode011", {8'h0, pd_out}, 16'h005A);
    wr(3'd0, 8'h22);
    pop(9'h111, "R7 first tagged entry");
    pop(9'h122, "R9 second entry in order");
    chk("R9 empty after drain", {15'h0, fifo_empty}, 16'h0001);

    // R8 reverse direction ignored
    wr(3'd2, 8'h20);
    wr(3'd0, 8'h33);
    chk("R8 reverse write no push", {15'h0, fifo_empty}, 16'h0001);
    wr(3'd2, 8'h00);

    // R9 / R10 capacity and overflow
    for (int i = 0; i < 16; i++) begin
      wr(3'd0, 8'(i + 8'h40));
      if (i == 14) chk("R9 not full at 15", {15'h0, fifo_full}, 16'h0000);
    end
    chk("R9 full at 16", {15'h0, fifo_full}, 16'h0001);
    chk("R10 no ovf yet", {15'h0, fifo_ovf}, 16'h0000);
    wr(3'd0, 8'h99);
    chk("R10 ovf set", {15'h0, fifo_ovf}, 16'h0001);
    for (int i = 0; i < 16; i++) pop({1'b1, 8'(i + 8'h40)}, "R10 drain without dropped byte");
    @(negedge clk);
    chk("R9 empty after 16 pops", {15'h0, fifo_empty}, 16'h0001);
    chk("R10 ovf sticky", {15'h0, fifo_ovf}, 16'h0001);

    // R12 pop on empty
    @(negedge clk); fifo_pop = 1'b1;
    @(negedge clk); fifo_pop = 1'b0;
    chk("R12 no rvalid on empty pop", {15'h0, fifo_rvalid}, 16'h0000);

    repeat (3) @(negedge clk);
    chk("R3 read scoreboard drained", 16'(rq.size()), 16'd0);
    chk("R12 pop scoreboard drained", 16'(fq.size()), 16'd0);
    finish_run();
  end
endmodule